// File: doc/BRIEF.md
# SRAM Write Timing Monitor

This block watches the control, address and data lines of an asynchronous static RAM bus. It samples them on a fast reference clock, where one clock period is one tick. It never drives the bus and holds no copy of the memory contents. A write is the span during which both active-low strobes, chip enable and write enable, are low. That span begins at the later of the two falling strobes and ends at the earlier of the two rising strobes. When a write ends, the monitor records which strobe ended it. It then judges the rest of the cycle against the limits for that kind of ending. Every timing limit is a parameter given in ticks.

The monitor also watches one input that shows whether the memory is driving its data pins. With it, the monitor checks when the output drivers turn off and turn back on around a write. Each rule owns a sticky flag that only reset clears. A single-cycle error pulse marks every sample that breaks one or more rules.

Control is a three-state machine. IDLE means no write is open and no post-write window is being timed. WRITE means a write is open. POST means the cycle after a write is being timed. The transitions are:

- IDLE to WRITE (`open`) when both strobes are seen low.
- WRITE to POST (`close`) when either strobe is seen high.
- POST to WRITE (`reopen`) when a new write opens.
- POST to IDLE (`expire`) once the post-write timer reaches the largest post-write limit.

Top module: `sram_wr_monitor`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every flag in `viol_flags` is 0 and `err_pulse` is 0.
- R2: Bit 0 of `viol_flags` is set when a write lasts fewer than `T_WP` samples. The write length counts the samples in which both strobes are low.
- R3: Bit 1 is set when, at the end of a write, the data lines have held their value for fewer than `T_DW` samples, counted back from the last sample of the write.
- R4: Bit 2 is set when the address changes between two consecutive samples that both lie inside one write.
- R5: A write whose end sees write enable rising is classed as write-enable ended. This includes the case where both strobes rise on the same sample. Otherwise it is classed as chip-enable ended. The class selects the limits used by R6 and R7.
- R6: Bit 3 is set when the address changes fewer than `T_WR1` samples after a write-enable ended write, or fewer than `T_WR2` samples after a chip-enable ended write. The sample where the write ended counts as 0.
- R7: Bit 4 is set when the data changes fewer than `T_DH1` samples after a write-enable ended write, or fewer than `T_DH2` samples after a chip-enable ended write. Elapsed samples are counted as in R6.
- R8: Bit 5 is set when `dq_drive` rises fewer than `T_OW` samples after a write ends. Elapsed samples are counted as in R6.
- R9: Bit 6 is set when `dq_drive` is high inside a write more than `T_WZ` samples after write enable fell. The sample where write enable fell counts as 0.
- R10: Bit 7 is set when `dq_drive` is high at any sample of a write that chip enable opened. Chip enable opened the write when it fell on the same sample as write enable, or on a later sample.
- R11: A flag, once set, stays set until reset. A rule broken by the inputs sampled at clock edge k shows on `viol_flags` and `err_pulse` after edge k+1. `err_pulse` is high for exactly those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Observed chip enable, active low |
| we_n | input | 1 | Observed write enable, active low |
| addr | input | ADDR_W | Observed address lines |
| wdata | input | DATA_W | Observed data lines |
| dq_drive | input | 1 | High while the memory drives its data pins |
| viol_flags | output | 8 | Sticky per-rule violation flags, bit order as in R2 to R10 |
| err_pulse | output | 1 | One-cycle marker of a sample with a new violation |

## Verification
The assertions assume that each input is settled at every reference edge. Any skew smaller than one tick appears as a same-sample event. The assertions also assume that every limit fits below the saturation value of the counters. The stimulus changes inputs only on the falling clock edge, one bus vector per tick, and holds both strobes high across every reset. Scenarios are kept short, so no counter approaches saturation.

// File: rtl/srmon_pkg.sv
package srmon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_POST  = 2'd2
    } phase_t;

    localparam int NRULE    = 8;
    localparam int RB_PULSE = 0;
    localparam int RB_SETUP = 1;
    localparam int RB_ADDR  = 2;
    localparam int RB_RECOV = 3;
    localparam int RB_HOLD  = 4;
    localparam int RB_EARLY = 5;
    localparam int RB_HIZ   = 6;
    localparam int RB_CEDRV = 7;

endpackage

// File: rtl/srmon_sampler.sv
module srmon_sampler #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              dq_drive,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              s_ce,
    output logic              s_we,
    output logic              p_ce,
    output logic              p_we,
    output logic              s_drv,
    output logic              p_drv,
    output logic              addr_chg,
    output logic              data_chg
);
    // bus vector layout: {ce, we, drv, addr, data}
    localparam int BW = 3 + ADDR_W + DATA_W;
    localparam logic [BW-1:0] BUS_RST = {2'b11, {(BW-2){1'b0}}};

    logic [BW-1:0] cur_q;
    logic [BW-1:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= BUS_RST;
            prv_q <= BUS_RST;
        end else begin
            cur_q <= {ce_n, we_n, dq_drive, addr, wdata};
            prv_q <= cur_q;
        end
    end

    assign s_ce     = cur_q[BW-1];
    assign s_we     = cur_q[BW-2];
    assign s_drv    = cur_q[BW-3];
    assign p_ce     = prv_q[BW-1];
    assign p_we     = prv_q[BW-2];
    assign p_drv    = prv_q[BW-3];
    assign addr_chg = cur_q[DATA_W +: ADDR_W] != prv_q[DATA_W +: ADDR_W];
    assign data_chg = cur_q[DATA_W-1:0] != prv_q[DATA_W-1:0];

endmodule

// File: rtl/srmon_tracker.sv
module srmon_tracker
    import srmon_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_WP  = 6,
    parameter int T_DW  = 3,
    parameter int T_WR1 = 1,
    parameter int T_WR2 = 2,
    parameter int T_DH1 = 0,
    parameter int T_DH2 = 1,
    parameter int T_OW  = 1,
    parameter int T_WZ  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_ce,
    input  logic             s_we,
    input  logic             p_ce,
    input  logic             p_we,
    input  logic             s_drv,
    input  logic             p_drv,
    input  logic             addr_chg,
    input  logic             data_chg,
    output logic [NRULE-1:0] viol
);
    localparam int MX_A   = (T_WR1 > T_WR2) ? T_WR1 : T_WR2;
    localparam int MX_B   = (T_DH1 > T_DH2) ? T_DH1 : T_DH2;
    localparam int MX_C   = (MX_A > MX_B) ? MX_A : MX_B;
    localparam int SPAN   = ((MX_C > T_OW) ? MX_C : T_OW) + 1;
    localparam logic [CNT_W-1:0] CMAX   = '1;
    localparam logic [CNT_W-1:0] L_WP   = CNT_W'(T_WP);
    localparam logic [CNT_W-1:0] L_DW   = CNT_W'(T_DW);
    localparam logic [CNT_W-1:0] L_WR1  = CNT_W'(T_WR1);
    localparam logic [CNT_W-1:0] L_WR2  = CNT_W'(T_WR2);
    localparam logic [CNT_W-1:0] L_DH1  = CNT_W'(T_DH1);
    localparam logic [CNT_W-1:0] L_DH2  = CNT_W'(T_DH2);
    localparam logic [CNT_W-1:0] L_OW   = CNT_W'(T_OW);
    localparam logic [CNT_W-1:0] L_WZ   = CNT_W'(T_WZ);
    localparam logic [CNT_W-1:0] L_SPAN = CNT_W'(SPAN);

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v == CMAX) ? v : v + 1'b1;
    endfunction

    phase_t state, state_nx;
    logic [CNT_W-1:0] win_len;    // window samples ending at previous sample
    logic [CNT_W-1:0] dat_age;    // data run length ending at previous sample
    logic [CNT_W-1:0] we_age;     // samples since write enable fell
    logic [CNT_W-1:0] post_age;   // samples since write ended (in POST)
    logic             term_we_q;
    logic             ce_open_q;

    logic             win, open_now, close_now, post_act, term_we, ce_open, drv_rise;
    logic [CNT_W-1:0] elapsed, rec_lim, hold_lim;

    assign win       = !s_ce && !s_we;
    assign open_now  = win && (state != PH_WRITE);
    assign close_now = !win && (state == PH_WRITE);
    assign post_act  = close_now || (state == PH_POST);
    assign elapsed   = close_now ? '0 : post_age;
    assign term_we   = close_now ? s_we : term_we_q;
    assign ce_open   = open_now ? p_ce : ce_open_q;
    assign drv_rise  = s_drv && !p_drv;
    assign rec_lim   = term_we ? L_WR1 : L_WR2;
    assign hold_lim  = term_we ? L_DH1 : L_DH2;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:  if (win) state_nx = PH_WRITE;
            PH_WRITE: if (!win) state_nx = PH_POST;
            PH_POST:  if (win) state_nx = PH_WRITE;
                      else if (post_age >= L_SPAN) state_nx = PH_IDLE;
            default:  state_nx = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    // timers and write classification
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len   <= '0;
            dat_age   <= '0;
            we_age    <= '0;
            post_age  <= '0;
            term_we_q <= 1'b1;
            ce_open_q <= 1'b0;
        end else begin
            win_len  <= win ? bump(win_len) : '0;
            dat_age  <= data_chg ? CNT_W'(1) : bump(dat_age);
            we_age   <= s_we ? '0 : bump(we_age);
            if (close_now)               post_age <= CNT_W'(1);
            else if (state == PH_POST)   post_age <= bump(post_age);
            else                         post_age <= '0;
            if (close_now) term_we_q <= s_we;
            if (open_now)  ce_open_q <= p_ce;
        end
    end

    // rule evaluation
    always_comb begin
        viol = '0;
        if (close_now && (win_len < L_WP))              viol[RB_PULSE] = 1'b1;
        if (close_now && (dat_age < L_DW))              viol[RB_SETUP] = 1'b1;
        if (win && (state == PH_WRITE) && addr_chg)     viol[RB_ADDR]  = 1'b1;
        if (post_act && addr_chg && (elapsed < rec_lim))  viol[RB_RECOV] = 1'b1;
        if (post_act && data_chg && (elapsed < hold_lim)) viol[RB_HOLD]  = 1'b1;
        if (post_act && drv_rise && (elapsed < L_OW))   viol[RB_EARLY] = 1'b1;
        if (win && s_drv && (we_age > L_WZ))            viol[RB_HIZ]   = 1'b1;
        if (win && s_drv && ce_open)                    viol[RB_CEDRV] = 1'b1;
    end

    // R2: WRITE phase always mirrors an open window in the previous sample
    a_r2_write_tracks_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WRITE) |-> (!p_ce && !p_we));
    // R4: address flag only between two in-window samples
    a_r4_addr_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        viol[RB_ADDR] |-> (!s_ce && !s_we && !p_ce && !p_we));
    // R6: recovery judged only after a write has ended
    a_r6_recov_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        viol[RB_RECOV] |-> (state != PH_IDLE) && !(!p_ce && !p_we && !s_ce && !s_we));
    // R9: late high-Z needs write enable low for more than one sample
    a_r9_hiz_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        viol[RB_HIZ] |-> (!s_we && !p_we && s_drv));
    // R10: chip-enable opened drive only inside a write
    a_r10_cedrv_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        viol[RB_CEDRV] |-> (s_drv && !s_ce && !s_we));

endmodule

// File: rtl/srmon_flags.sv
module srmon_flags #(
    parameter int NR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NR-1:0] viol,
    output logic [NR-1:0] flags,
    output logic          err_pulse
);
    for (genvar g = 0; g < NR; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[g] <= 1'b0;
            else if (viol[g]) flags[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= |viol;
    end

    // R11: flags never clear outside reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags) == '0));
    // R11: any violation yields a pulse on the next cycle
    a_r11_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (viol != '0) |=> err_pulse);
    // R11: a pulse is always accompanied by a set flag
    a_r11_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (flags != '0));

endmodule

// File: rtl/sram_wr_monitor.sv
module sram_wr_monitor
    import srmon_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int T_WP   = 6,
    parameter int T_DW   = 3,
    parameter int T_WR1  = 1,
    parameter int T_WR2  = 2,
    parameter int T_DH1  = 0,
    parameter int T_DH2  = 1,
    parameter int T_OW   = 1,
    parameter int T_WZ   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dq_drive,
    output logic [7:0]        viol_flags,
    output logic              err_pulse
);
    logic s_ce, s_we, p_ce, p_we, s_drv, p_drv, addr_chg, data_chg;
    logic [NRULE-1:0] viol;

    srmon_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dq_drive(dq_drive),
        .addr(addr), .wdata(wdata),
        .s_ce(s_ce), .s_we(s_we), .p_ce(p_ce), .p_we(p_we),
        .s_drv(s_drv), .p_drv(p_drv), .addr_chg(addr_chg), .data_chg(data_chg)
    );

    srmon_tracker #(
        .CNT_W(CNT_W), .T_WP(T_WP), .T_DW(T_DW), .T_WR1(T_WR1), .T_WR2(T_WR2),
        .T_DH1(T_DH1), .T_DH2(T_DH2), .T_OW(T_OW), .T_WZ(T_WZ)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .s_ce(s_ce), .s_we(s_we), .p_ce(p_ce), .p_we(p_we),
        .s_drv(s_drv), .p_drv(p_drv), .addr_chg(addr_chg), .data_chg(data_chg),
        .viol(viol)
    );

    srmon_flags #(.NR(NRULE)) u_flg (
        .clk(clk), .rst_n(rst_n), .viol(viol), .flags(viol_flags), .err_pulse(err_pulse)
    );

endmodule

// File: tb/sim_sram_wr_monitor.sv
module sim_sram_wr_monitor;
    localparam int AW = 13, DW = 8;
    localparam int WP = 6, DWT = 3, WR1 = 1, WR2 = 2, DH1 = 0, DH2 = 1, OW = 1, WZ = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, drv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [7:0] viol_flags;
    logic err_pulse;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_wr_monitor u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .dq_drive(drv), .viol_flags(viol_flags), .err_pulse(err_pulse)
    );

    // behavioural reference state (timestamps in sample indices)
    int n, t_open, last_dchg, t_end, t_wefall;
    bit in_post, term_we, open_ce;
    logic pce, pwe, pdrv;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    logic [7:0] mflags, e1_f, e2_f;
    bit e1_p, e2_p, saw_pulse;

    task automatic model_reset();
        n = 0; t_open = 0; last_dchg = 0; t_end = 0; t_wefall = 0;
        in_post = 0; term_we = 1; open_ce = 0;
        pce = 1; pwe = 1; pdrv = 0; pa = '0; pd = '0;
        mflags = '0; e1_f = '0; e2_f = '0; e1_p = 0; e2_p = 0; saw_pulse = 0;
    endtask

    task automatic model_step(input logic ce, input logic we, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input logic dr);
        logic [7:0] v;
        bit w, pw;
        int e;
        v = '0;
        w = !ce && !we;
        pw = !pce && !pwe;
        if (!we && pwe) t_wefall = n;
        if (w && !pw) begin t_open = n; open_ce = pce; end
        if (pw && !w) begin
            if (n - t_open < WP) v[0] = 1;
            if (n - last_dchg < DWT) v[1] = 1;
            term_we = we;
            in_post = 1;
            t_end = n;
        end
        if (w && pw && a != pa) v[2] = 1;
        if (in_post) begin
            e = n - t_end;
            if (a != pa && e < (term_we ? WR1 : WR2)) v[3] = 1;
            if (d != pd && e < (term_we ? DH1 : DH2)) v[4] = 1;
            if (dr && !pdrv && e < OW) v[5] = 1;
        end
        if (w && !pw) in_post = 0;
        if (w && dr && (n - t_wefall) > WZ) v[6] = 1;
        if (w && dr && open_ce) v[7] = 1;
        if (d != pd) last_dchg = n;
        pce = ce; pwe = we; pa = a; pd = d; pdrv = dr;
        n++;
        mflags |= v;
        e2_f = e1_f; e2_p = e1_p;
        e1_f = mflags; e1_p = (v != 0);
    endtask

    task automatic step(input logic ce, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic dr);
        checks++;
        if (viol_flags !== e2_f || err_pulse !== e2_p) begin
            errors++;
            $display("FAIL R11 cycle compare: flags=%b pulse=%b expected flags=%b pulse=%b",
                     viol_flags, err_pulse, e2_f, e2_p);
        end
        if (err_pulse === 1'b1) saw_pulse = 1;
        ce_n = ce; we_n = we; addr = a; wdata = d; drv = dr;
        model_step(ce, we, a, d, dr);
        @(negedge clk);
    endtask

    task automatic idle(input int cnt, input logic [AW-1:0] a, input logic [DW-1:0] d);
        for (int i = 0; i < cnt; i++) step(1, 1, a, d, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; ce_n = 1; we_n = 1; addr = '0; wdata = '0; drv = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (viol_flags !== 8'h00 || err_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: flags=%b pulse=%b expected 00000000 0", viol_flags, err_pulse);
        end
        rst_n = 1;
        model_reset();
    endtask

    task automatic expect_mask(input logic [7:0] exp, input string tag);
        checks++;
        if (viol_flags !== exp) begin
            errors++;
            $display("FAIL %s flags=%b expected %b", tag, viol_flags, exp);
        end
    endtask

    task automatic expect_pulse(input bit exp, input string tag);
        checks++;
        if (saw_pulse != exp) begin
            errors++;
            $display("FAIL %s pulse seen=%0d expected %0d", tag, saw_pulse, exp);
        end
    endtask

    // generic write: ce falls, we low for 'lows' samples, then end
    initial begin
        @(negedge clk);
        // R1 / clean write-enable ended write
        do_reset();
        checks++;
        if (viol_flags !== 8'h00 || err_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 after release: flags=%b pulse=%b expected 0 0", viol_flags, err_pulse);
        end
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h6, 8'hAA, 0);
        idle(4, 13'h6, 8'hAA);
        expect_mask(8'h00, "R2 clean write");
        expect_pulse(0, "R11 no pulse on clean write");

        // R2 short pulse
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h01, "R2 short write");
        expect_pulse(1, "R11 pulse on short write");

        // R3 late data
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 13'h5, (i >= 6) ? 8'h55 : 8'hAA, 0);
        step(0, 1, 13'h5, 8'h55, 0);
        idle(4, 13'h5, 8'h55);
        expect_mask(8'h02, "R3 data setup");

        // R4 address moves in window
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 8; i++) step(0, 0, (i >= 3) ? 13'h9 : 13'h5, 8'hAA, 0);
        step(0, 1, 13'h9, 8'hAA, 0);
        idle(4, 13'h9, 8'hAA);
        expect_mask(8'h04, "R4 address move");

        // R5/R6/R7 write-enable ended, tight but legal follow-up
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hBB, 0);
        step(0, 1, 13'h7, 8'hBB, 0);
        idle(4, 13'h7, 8'hBB);
        expect_mask(8'h00, "R6 R7 write-enable ended pass");

        // R5/R6/R7 chip-enable ended, same spacing fails
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(1, 0, 13'h5, 8'hBB, 0);
        step(1, 0, 13'h7, 8'hBB, 0);
        idle(4, 13'h7, 8'hBB);
        expect_mask(8'h18, "R5 R6 R7 chip-enable ended");

        // R5 tie goes to write enable
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(1, 1, 13'h5, 8'hBB, 0);
        step(1, 1, 13'h7, 8'hBB, 0);
        idle(4, 13'h7, 8'hBB);
        expect_mask(8'h00, "R5 simultaneous end");

        // R8 drive too early
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 1);
        step(0, 1, 13'h5, 8'hAA, 1);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h20, "R8 drive early");

        // R9 high-Z reached in time
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 1);
        step(0, 1, 13'h5, 8'hAA, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 13'h5, 8'hAA, i <= WZ);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h00, "R9 high-Z in time");

        // R9 high-Z too late
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 1, 13'h5, 8'hAA, 1);
        step(0, 1, 13'h5, 8'hAA, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 13'h5, 8'hAA, i <= WZ + 1);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h40, "R9 high-Z late");

        // R10 chip enable falls after write enable
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(1, 0, 13'h5, 8'hAA, 0);
        step(0, 0, 13'h5, 8'hAA, 1);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h80, "R10 chip enable opened");

        // R10 both strobes fall together
        do_reset();
        idle(2, 13'h5, 8'hAA);
        step(0, 0, 13'h5, 8'hAA, 1);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h80, "R10 simultaneous open");

        // R11 flags stay after a later clean write
        step(0, 1, 13'h5, 8'hAA, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 13'h5, 8'hAA, 0);
        step(0, 1, 13'h5, 8'hAA, 0);
        idle(4, 13'h5, 8'hAA);
        expect_mask(8'h80, "R11 sticky");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule